// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block collects event pulses from three timers into one 8-bit flag byte and turns the flags into interrupt requests. Every flag is a sticky bit. An event pulse sets it. Software clears it by writing a one to its position. The CPU's acknowledgement of the matching vector also clears it. A separate 8-bit enable byte works alongside a global interrupt enable to decide which flags raise a request.

A fixed-priority encoder picks the lowest-numbered active request and reports its index, together with a valid strobe. The CPU acknowledges that index back into the block. For timer1 and timer2, a mode input per timer selects the overflow source. In normal counting the overflow flag follows the top-wrap pulse. In up/down PWM counting it follows the reversal pulse at zero instead.

The bus decoder, the timers and the CPU sit outside the block. They appear here only as write strobes, event pulses and an acknowledge port.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset the flag byte and the enable byte both read 0x00, and no request or valid vector is present.
- R2: An event pulse sets its flag on the next clock edge. The bit positions are: 7 timer2 compare, 6 timer2 overflow, 5 timer1 capture, 4 timer1 compare A, 3 timer1 compare B, 2 timer1 overflow, 1 reserved, 0 timer0 overflow.
- R3: A flag write clears every flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: An acknowledge with index k clears flag k only. All other flags are left untouched.
- R5: If an event arrives in the same cycle as a clear by write or by acknowledge, the flag ends up set.
- R6: Bit 1 of the flag byte always reads 0. No event, write or acknowledge changes it.
- R7: Request bit k is 1 exactly when the global enable, enable bit k and flag k are all 1.
- R8: The vector valid strobe is 1 when any request is active. The vector index then equals the lowest-numbered active request.
- R9: When a timer's dual-slope mode input is 1, its overflow flag follows the bottom-reversal pulse and ignores the top pulse. When the mode input is 0, the flag follows the top pulse and ignores the bottom pulse.
- R10: An enable write loads all 8 bits of the enable byte from the write data on the next clock edge. A flag read has no effect on either byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t0_wrap | input | 1 | Timer0 overflow pulse |
| t1_wrap_top | input | 1 | Timer1 overflow at top |
| t1_wrap_bot | input | 1 | Timer1 direction reversal at zero |
| t1_dual | input | 1 | Timer1 dual-slope mode select |
| t1_cmp_a | input | 1 | Timer1 compare A match pulse |
| t1_cmp_b | input | 1 | Timer1 compare B match pulse |
| t1_capt | input | 1 | Timer1 capture transfer pulse |
| t2_wrap_top | input | 1 | Timer2 overflow at top |
| t2_wrap_bot | input | 1 | Timer2 direction reversal at zero |
| t2_dual | input | 1 | Timer2 dual-slope mode select |
| t2_cmp | input | 1 | Timer2 compare match pulse |
| flag_we | input | 1 | Flag byte write strobe |
| en_we | input | 1 | Enable byte write strobe |
| wdata | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| ack | input | 1 | Vector acknowledge strobe |
| ack_idx | input | 3 | Index being acknowledged |
| flags | output | 8 | Flag byte read value |
| enables | output | 8 | Enable byte read value |
| irq | output | 8 | Per-source request lines |
| vec_idx | output | 3 | Lowest active request index |
| vec_valid | output | 1 | Any request active |

## Verification
On every cycle, the assertions check four things: event pulses set their flags, a write-one clear takes effect, an acknowledge clears only its own flag, and requests are gated by the global enable. They also check that the reported vector is an active request with nothing lower active. Some behaviour only the bench's scenarios can show. These are the exact byte values after combined event, write and acknowledge traffic, the overflow source selection under each mode setting, and the guarantee that the reserved bit never moves. The bench shows them by comparing against an arithmetic model over a long pseudo-random sweep plus directed corner cases.

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int W  = 8,
  parameter int IW = $clog2(W),
  parameter int RSV = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t0_wrap,
  input  logic          t1_wrap_top,
  input  logic          t1_wrap_bot,
  input  logic          t1_dual,
  input  logic          t1_cmp_a,
  input  logic          t1_cmp_b,
  input  logic          t1_capt,
  input  logic          t2_wrap_top,
  input  logic          t2_wrap_bot,
  input  logic          t2_dual,
  input  logic          t2_cmp,
  input  logic          flag_we,
  input  logic          en_we,
  input  logic [W-1:0]  wdata,
  input  logic          gie,
  input  logic          ack,
  input  logic [IW-1:0] ack_idx,
  output logic [W-1:0]  flags,
  output logic [W-1:0]  enables,
  output logic [W-1:0]  irq,
  output logic [IW-1:0] vec_idx,
  output logic          vec_valid
);

  logic t1_ovf_ev, t2_ovf_ev;
  logic [W-1:0] ev, wr_clr, ack_clr, nxt, keep;

  assign t1_ovf_ev = t1_dual ? t1_wrap_bot : t1_wrap_top;
  assign t2_ovf_ev = t2_dual ? t2_wrap_bot : t2_wrap_top;

  assign ev      = {t2_cmp, t2_ovf_ev, t1_capt, t1_cmp_a, t1_cmp_b, t1_ovf_ev, 1'b0, t0_wrap};
  assign wr_clr  = flag_we ? wdata : '0;
  assign ack_clr = ack ? (W'(1) << ack_idx) : '0;
  assign keep    = ~(W'(1) << RSV);
  assign nxt     = ((flags & ~(wr_clr | ack_clr)) | ev) & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= nxt;
      if (en_we) enables <= wdata;
    end
  end

  assign irq = flags & enables & {W{gie}};

  always_comb begin
    vec_idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (irq[i]) vec_idx = IW'(i);
  end

  assign vec_valid = |irq;

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t0_wrap |=> flags[0]);
  assert_event_sets_t2cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    t2_cmp |=> flags[7]);
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && wdata[4] && !t1_cmp_a) |=> !flags[4]);
  assert_write_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !wdata[5] && !ack && flags[5]) |=> flags[5]);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx == 3'd3 && !t1_cmp_b) |=> !flags[3]);
  assert_ack_spares_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_idx == 3'd3 && !flag_we && flags[4]) |=> flags[4]);
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_capt && (flag_we || ack)) |=> flags[5]);
  assert_gie_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> gie);
  assert_vec_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (irq[vec_idx] && ((irq & ((W'(1) << vec_idx) - W'(1))) == '0)));
  assert_mode_ignores_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_dual && t1_wrap_top && !t1_wrap_bot && !flags[2]) |=> !flags[2]);
  assert_enable_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (enables == $past(wdata)));

endmodule

// File: tb/tmr_irq_flags_bench.sv
module tmr_irq_flags_bench;
  logic clk = 0, rst_n = 0;
  logic t0_wrap = 0, t1_wrap_top = 0, t1_wrap_bot = 0, t1_dual = 0;
  logic t1_cmp_a = 0, t1_cmp_b = 0, t1_capt = 0;
  logic t2_wrap_top = 0, t2_wrap_bot = 0, t2_dual = 0, t2_cmp = 0;
  logic flag_we = 0, en_we = 0, gie = 0, ack = 0;
  logic [7:0] wdata = 0;
  logic [2:0] ack_idx = 0;
  logic [7:0] flags, enables, irq;
  logic [2:0] vec_idx;
  logic vec_valid;

  int checks = 0, fails = 0;
  logic [7:0] mf = 0, mm = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_flags u_tmr_irq_flags (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ev bits: 10 t2_dual,9 t2_cmp,8 t2_bot,7 t2_top,6 t1_capt,5 cmp_a,4 cmp_b,3 t1_dual,2 t1_bot,1 t1_top,0 t0_wrap
  task automatic step(input logic [10:0] e, input logic wf, input logic wm, input logic [7:0] wd,
                      input logic g, input logic a, input logic [2:0] ai);
    logic [7:0] ev, clr, ex_irq;
    logic [2:0] ex_vec;
    {t2_dual, t2_cmp, t2_wrap_bot, t2_wrap_top, t1_capt, t1_cmp_a, t1_cmp_b,
     t1_dual, t1_wrap_bot, t1_wrap_top, t0_wrap} = e;
    flag_we = wf; en_we = wm; wdata = wd; gie = g; ack = a; ack_idx = ai;
    ev = {e[9], e[10] ? e[8] : e[7], e[6], e[5], e[4], e[3] ? e[2] : e[1], 1'b0, e[0]};
    clr = (wf ? wd : 8'h00) | (a ? (8'd1 << ai) : 8'h00);
    mf = ((mf & ~clr) | ev) & 8'hFD;
    if (wm) mm = wd;
    @(posedge clk);
    @(negedge clk);
    ex_irq = mf & mm & {8{g}};
    ex_vec = 0;
    for (int i = 7; i >= 0; i--) if (ex_irq[i]) ex_vec = 3'(i);
    chk("R2 flags", flags, mf);
    chk("R10 enables", enables, mm);
    chk("R7 irq", irq, ex_irq);
    chk("R8 vec", {4'b0, vec_valid, vec_idx}, {4'b0, |ex_irq, ex_vec});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    @(negedge clk);
    chk("R1 flags reset", flags, 8'h00);
    chk("R1 enables reset", enables, 8'h00);
    chk("R1 no request", {irq[6:0], vec_valid}, 8'h00);

    // R2: each event alone
    step(11'h001, 0, 1, 8'hFF, 1, 0, 0); chk("R2 t0 bit0", flags, 8'h01);
    step(11'h200, 1, 0, 8'hFF, 1, 0, 0); chk("R2 t2cmp bit7", flags, 8'h80);
    step(11'h040, 1, 0, 8'hFF, 1, 0, 0); chk("R2 capture bit5", flags, 8'h20);
    // R3: write zeros keeps, write one clears
    step(11'h030, 1, 0, 8'h00, 1, 0, 0); chk("R3 write zero keeps", flags, 8'h38);
    step(11'h000, 1, 0, 8'h10, 1, 0, 0); chk("R3 write one clears", flags, 8'h28);
    // R4: ack clears only its index
    step(11'h000, 0, 0, 8'h00, 1, 1, 3'd3); chk("R4 ack only idx", flags, 8'h20);
    // R5: event beats clear
    step(11'h040, 1, 0, 8'hFF, 1, 1, 3'd5); chk("R5 event wins", flags, 8'h20);
    // R6: reserved bit
    step(11'h7FF, 0, 0, 8'h00, 1, 0, 0); chk("R6 reserved zero", {7'b0, flags[1]}, 8'h00);
    step(11'h000, 1, 0, 8'hFF, 1, 0, 0);
    // R9: mode select
    step(11'h408, 0, 0, 8'h00, 1, 0, 0); step(11'h082, 0, 0, 8'h00, 1, 0, 0);
    chk("R9 mode0 ignores bottom, top sets", flags, 8'h44);
    step(11'h000, 1, 0, 8'hFF, 1, 0, 0);
    step(11'h48A, 0, 0, 8'h00, 1, 0, 0); chk("R9 dual ignores top", flags, 8'h00);
    step(11'h50C, 0, 0, 8'h00, 1, 0, 0); chk("R9 dual bottom sets", flags, 8'h44);
    // R7: global enable off
    step(11'h000, 0, 0, 8'h00, 0, 0, 0); chk("R7 gie off", irq, 8'h00);
    // R8: lowest wins
    step(11'h001, 0, 0, 8'h00, 1, 0, 0); chk("R8 lowest idx", {5'b0, vec_idx}, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      r = seed;
      step(r[10:0] & r[21:11], r[22] & r[23], r[24] & r[25] & r[26], r[31:24], r[27] | r[28],
           r[29], r[20:18]);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule